// File: doc/BRIEF.md
# I2C Controller Clock and Control Core

This block is the register-facing core of an I2C controller. It generates the serial clock (SCL) from two separately programmable 8-bit period values, one for the high phase and one for the low phase. Both are counted in cycles of the core clock. It holds a transmit FIFO and a receive FIFO. It raises a single interrupt from the enabled FIFO conditions. It also runs a one-shot soft reset that returns the controller to idle without losing its configuration.

Software reaches the block through a word-wide register port and through two byte streams. The host pushes bytes into the transmit FIFO and pops bytes from the receive FIFO. On the other side, the protocol engine drains the transmit FIFO, fills the receive FIFO, and reports bus events on a plain event input that the block collects into a sticky status word.

All four byte streams use valid/ready. A byte moves on a rising clock edge where valid and ready are both high. A producer holds valid and data steady until that edge. A FIFO drops ready when it is full, and it drops both ready and valid while a soft reset is pending, so that no byte enters or leaves during the flush.

Top module: `i2c_ctl_core`

## Requirements
- R1: After reset, the control word reads 0, the high-period and low-period registers (addresses 1 and 2) each read 0xB9, SCL is 1 and the interrupt is 0.
- R2: SCL starts high after reset or soft reset. It stays high for exactly N cycles, where N is the high-period value, then low for exactly M cycles, where M is the low-period value, and repeats.
- R3: A new period value that is written during a phase first applies at the next phase of its kind. The phase already running keeps the length it started with.
- R4: A period value of 0 gives a phase of one cycle, so SCL never stops toggling.
- R5: The interrupt equals (control bit 6 AND receive FIFO not empty) OR (control bit 7 AND transmit FIFO not full). It follows each of these terms within the same cycle.
- R6: Each FIFO holds 4 bytes and returns them in order. When the FIFO is full, its input ready is 0 and further pushes are not taken.
- R7: Writing 1 to control bit 8 makes that bit read 1 for one cycle, after which it clears itself. At the following edge both FIFOs empty, status bits 3:0 clear and SCL restarts a full high phase.
- R8: A soft reset leaves the high-period register, the low-period register and control bits 7:0 unchanged.
- R9: Writes to control bits 31:9 are ignored, and those bits read 0. Writes to the status address (3) have no effect.
- R10: Status bits 3:0 latch any high bit of the event input until the next soft reset. Status bit 4 reads 1 while the receive FIFO is not empty. Status bit 5 reads 1 while the transmit FIFO is not full.
- R11: While a soft reset is pending, every FIFO ready and valid output is 0, so a push offered in that cycle is discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address: 0 control, 1 high period, 2 low period, 3 status |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for reg_addr (combinational) |
| host_tx_valid | input | 1 | Host offers a byte for transmission |
| host_tx_ready | output | 1 | Transmit FIFO accepts a byte |
| host_tx_data | input | 8 | Byte to transmit |
| eng_tx_valid | output | 1 | Transmit FIFO has a byte for the engine |
| eng_tx_ready | input | 1 | Engine takes the byte |
| eng_tx_data | output | 8 | Oldest transmit byte |
| eng_rx_valid | input | 1 | Engine offers a received byte |
| eng_rx_ready | output | 1 | Receive FIFO accepts a byte |
| eng_rx_data | input | 8 | Received byte |
| host_rx_valid | output | 1 | Receive FIFO has a byte for the host |
| host_rx_ready | input | 1 | Host takes the byte |
| host_rx_data | output | 8 | Oldest received byte |
| eng_evt | input | 4 | Event flags from the protocol engine |
| irq | output | 1 | Interrupt request |
| scl | output | 1 | Serial clock output |

## Verification
Two pairs of events can fall on the same edge. The first pair is the soft-reset flush and a FIFO push. The bench offers a transmit byte in exactly the cycle where control bit 8 still reads 1. It then judges that ready was low and that the FIFO is empty after the flush. The second pair is a period write and an SCL phase change. The bench writes a new high period on the first cycle of a high phase. It then requires that phase to keep its old length and the next high phase to take the new one.

// File: rtl/i2cc_pkg.sv
package i2cc_pkg;
  localparam int DATA_W  = 32;
  localparam int DIV_W   = 8;
  localparam int BYTE_W  = 8;
  localparam int EVT_W   = 4;
  localparam int CTRL_W  = 8;
  localparam int BIT_RXIE = 6;
  localparam int BIT_TXIE = 7;
  localparam int BIT_SRST = 8;
  localparam logic [DIV_W-1:0] DIV_RESET = 8'hB9;

  typedef enum logic [1:0] {
    ADDR_CTRL = 2'd0,
    ADDR_HIGH = 2'd1,
    ADDR_LOW  = 2'd2,
    ADDR_STAT = 2'd3
  } reg_addr_e;
endpackage

// File: rtl/i2cc_fifo.sv
module i2cc_fifo #(
  parameter int WIDTH = 8,
  parameter int DEPTH = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             flush,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [WIDTH-1:0] in_data,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [WIDTH-1:0] out_data,
  output logic             full,
  output logic             empty
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [AW-1:0]    wr_ptr, rd_ptr;
  logic [CW-1:0]    count;
  logic             push, pop;

  assign full      = (count == CW'(DEPTH));
  assign empty     = (count == '0);
  assign in_ready  = !full && !flush;
  assign out_valid = !empty && !flush;
  assign out_data  = mem[rd_ptr];
  assign push      = in_valid && in_ready;
  assign pop       = out_valid && out_ready;

  always_ff @(posedge clk) begin
    if (push) mem[wr_ptr] <= in_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else if (flush) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (push) wr_ptr <= (wr_ptr == LAST) ? '0 : wr_ptr + 1'b1;
      if (pop)  rd_ptr <= (rd_ptr == LAST) ? '0 : rd_ptr + 1'b1;
      count <= count + CW'(push) - CW'(pop);
    end
  end
endmodule

// File: rtl/i2cc_scl_gen.sv
module i2cc_scl_gen #(
  parameter int              CW      = 8,
  parameter logic [CW-1:0]   RST_DIV = 8'hB9
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          restart,
  input  logic [CW-1:0] hi_div,
  input  logic [CW-1:0] lo_div,
  output logic          scl
);
  logic [CW-1:0] remain;
  logic          scl_q;

  function automatic logic [CW-1:0] load_val(input logic [CW-1:0] v);
    return (v == '0) ? '0 : v - 1'b1;
  endfunction

  assign scl = scl_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q  <= 1'b1;
      remain <= load_val(RST_DIV);
    end else if (restart) begin
      scl_q  <= 1'b1;
      remain <= load_val(hi_div);
    end else if (remain == '0) begin
      scl_q  <= !scl_q;
      remain <= scl_q ? load_val(lo_div) : load_val(hi_div);
    end else begin
      remain <= remain - 1'b1;
    end
  end
endmodule

// File: rtl/i2cc_regs.sv
module i2cc_regs
  import i2cc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr,
  input  logic [1:0]        addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  input  logic [EVT_W-1:0]  evt,
  input  logic              rx_nonempty,
  input  logic              tx_notfull,
  output logic [DIV_W-1:0]  hi_div,
  output logic [DIV_W-1:0]  lo_div,
  output logic              rx_ie,
  output logic              tx_ie,
  output logic              srst,
  output logic              irq
);
  logic [CTRL_W-1:0] ctrl_q;
  logic [EVT_W-1:0]  sticky_q;
  logic              srst_q;
  reg_addr_e         sel;

  assign sel    = reg_addr_e'(addr);
  assign rx_ie  = ctrl_q[BIT_RXIE];
  assign tx_ie  = ctrl_q[BIT_TXIE];
  assign srst   = srst_q;
  assign irq    = (rx_ie && rx_nonempty) || (tx_ie && tx_notfull);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q   <= '0;
      srst_q   <= 1'b0;
      hi_div   <= DIV_RESET;
      lo_div   <= DIV_RESET;
      sticky_q <= '0;
    end else begin
      srst_q   <= 1'b0;
      sticky_q <= srst_q ? '0 : (sticky_q | evt);
      if (wr) begin
        case (sel)
          ADDR_CTRL: begin
            ctrl_q <= wdata[CTRL_W-1:0];
            srst_q <= wdata[BIT_SRST];
          end
          ADDR_HIGH: hi_div <= wdata[DIV_W-1:0];
          ADDR_LOW:  lo_div <= wdata[DIV_W-1:0];
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    rdata = '0;
    case (sel)
      ADDR_CTRL: begin
        rdata[CTRL_W-1:0] = ctrl_q;
        rdata[BIT_SRST]   = srst_q;
      end
      ADDR_HIGH: rdata[DIV_W-1:0] = hi_div;
      ADDR_LOW:  rdata[DIV_W-1:0] = lo_div;
      default: begin
        rdata[EVT_W-1:0] = sticky_q;
        rdata[EVT_W]     = rx_nonempty;
        rdata[EVT_W+1]   = tx_notfull;
      end
    endcase
  end
endmodule

// File: rtl/i2c_ctl_core.sv
module i2c_ctl_core
  import i2cc_pkg::*;
#(
  parameter int FIFO_DEPTH = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [1:0]        reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic              host_tx_valid,
  output logic              host_tx_ready,
  input  logic [BYTE_W-1:0] host_tx_data,
  output logic              eng_tx_valid,
  input  logic              eng_tx_ready,
  output logic [BYTE_W-1:0] eng_tx_data,
  input  logic              eng_rx_valid,
  output logic              eng_rx_ready,
  input  logic [BYTE_W-1:0] eng_rx_data,
  output logic              host_rx_valid,
  input  logic              host_rx_ready,
  output logic [BYTE_W-1:0] host_rx_data,
  input  logic [EVT_W-1:0]  eng_evt,
  output logic              irq,
  output logic              scl
);
  logic             srst_pulse;
  logic             rx_ie, tx_ie;
  logic             tx_full, tx_empty, rx_full, rx_empty;
  logic [DIV_W-1:0] hi_div, lo_div;

  i2cc_regs u_regs (
    .clk         (clk),
    .rst_n       (rst_n),
    .wr          (reg_wr),
    .addr        (reg_addr),
    .wdata       (reg_wdata),
    .rdata       (reg_rdata),
    .evt         (eng_evt),
    .rx_nonempty (!rx_empty),
    .tx_notfull  (!tx_full),
    .hi_div      (hi_div),
    .lo_div      (lo_div),
    .rx_ie       (rx_ie),
    .tx_ie       (tx_ie),
    .srst        (srst_pulse),
    .irq         (irq)
  );

  i2cc_fifo #(.WIDTH(BYTE_W), .DEPTH(FIFO_DEPTH)) u_tx_fifo (
    .clk       (clk),
    .rst_n     (rst_n),
    .flush     (srst_pulse),
    .in_valid  (host_tx_valid),
    .in_ready  (host_tx_ready),
    .in_data   (host_tx_data),
    .out_valid (eng_tx_valid),
    .out_ready (eng_tx_ready),
    .out_data  (eng_tx_data),
    .full      (tx_full),
    .empty     (tx_empty)
  );

  i2cc_fifo #(.WIDTH(BYTE_W), .DEPTH(FIFO_DEPTH)) u_rx_fifo (
    .clk       (clk),
    .rst_n     (rst_n),
    .flush     (srst_pulse),
    .in_valid  (eng_rx_valid),
    .in_ready  (eng_rx_ready),
    .in_data   (eng_rx_data),
    .out_valid (host_rx_valid),
    .out_ready (host_rx_ready),
    .out_data  (host_rx_data),
    .full      (rx_full),
    .empty     (rx_empty)
  );

  i2cc_scl_gen #(.CW(DIV_W), .RST_DIV(DIV_RESET)) u_scl (
    .clk     (clk),
    .rst_n   (rst_n),
    .restart (srst_pulse),
    .hi_div  (hi_div),
    .lo_div  (lo_div),
    .scl     (scl)
  );
endmodule

// File: rtl/i2cc_checker.sv
module i2cc_checker (
  input logic        clk,
  input logic        rst_n,
  input logic        reg_wr,
  input logic [1:0]  reg_addr,
  input logic [31:0] reg_wdata,
  input logic        scl,
  input logic        irq,
  input logic        srst,
  input logic        rx_ie,
  input logic        tx_ie,
  input logic        tx_full,
  input logic        host_tx_ready,
  input logic        eng_rx_ready,
  input logic        eng_tx_valid,
  input logic        host_rx_valid,
  input logic [7:0]  hi_div,
  input logic [7:0]  lo_div
);
  logic [8:0] run_len;
  logic       scl_prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_len  <= '0;
      scl_prev <= 1'b1;
    end else begin
      scl_prev <= scl;
      if (srst || scl != scl_prev) run_len <= '0;
      else if (run_len != 9'h1FF)  run_len <= run_len + 1'b1;
    end
  end

  assert_scl_toggles_R4: assert property (@(posedge clk) disable iff (!rst_n)
    run_len < 9'd256);

  assert_irq_rx_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_ie && host_rx_valid) |-> irq);

  assert_irq_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!rx_ie && !tx_ie) |-> !irq);

  assert_no_overflow_R6: assert property (@(posedge clk) disable iff (!rst_n)
    tx_full |-> !host_tx_ready);

  assert_srst_selfclear_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (srst && !(reg_wr && reg_addr == 2'd0 && reg_wdata[8])) |=> !srst);

  assert_flush_empties_R7: assert property (@(posedge clk) disable iff (!rst_n)
    srst |=> (!eng_tx_valid && !host_rx_valid));

  assert_keep_div_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (srst && !reg_wr) |=> ($stable(hi_div) && $stable(lo_div)));

  assert_push_blocked_R11: assert property (@(posedge clk) disable iff (!rst_n)
    srst |-> (!host_tx_ready && !eng_rx_ready));
endmodule

bind i2c_ctl_core i2cc_checker u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .reg_wr        (reg_wr),
  .reg_addr      (reg_addr),
  .reg_wdata     (reg_wdata),
  .scl           (scl),
  .irq           (irq),
  .srst          (srst_pulse),
  .rx_ie         (rx_ie),
  .tx_ie         (tx_ie),
  .tx_full       (tx_full),
  .host_tx_ready (host_tx_ready),
  .eng_rx_ready  (eng_rx_ready),
  .eng_tx_valid  (eng_tx_valid),
  .host_rx_valid (host_rx_valid),
  .hi_div        (hi_div),
  .lo_div        (lo_div)
);

// File: tb/i2c_ctl_core_test.sv
module i2c_ctl_core_test;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 150000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [1:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        host_tx_valid = 1'b0;
  logic        host_tx_ready;
  logic [7:0]  host_tx_data = '0;
  logic        eng_tx_valid;
  logic        eng_tx_ready = 1'b0;
  logic [7:0]  eng_tx_data;
  logic        eng_rx_valid = 1'b0;
  logic        eng_rx_ready;
  logic [7:0]  eng_rx_data = '0;
  logic        host_rx_valid;
  logic        host_rx_ready = 1'b0;
  logic [7:0]  host_rx_data;
  logic [3:0]  eng_evt = '0;
  logic        irq;
  logic        scl;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  i2c_ctl_core uut (.*);

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic reg_write(input logic [1:0] a, input logic [31:0] d);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic reg_read(input logic [1:0] a, output logic [31:0] d);
    reg_addr = a;
    #1;
    d = reg_rdata;
  endtask

  task automatic host_push(input logic [7:0] d);
    host_tx_valid = 1'b1; host_tx_data = d;
    @(negedge clk);
    host_tx_valid = 1'b0;
  endtask

  task automatic eng_push(input logic [7:0] d);
    eng_rx_valid = 1'b1; eng_rx_data = d;
    @(negedge clk);
    eng_rx_valid = 1'b0;
  endtask

  task automatic measure(output int h, output int l);
    logic prev = scl;
    forever begin
      @(negedge clk);
      if (prev && !scl) break;
      prev = scl;
    end
    l = 1;
    forever begin @(negedge clk); if (scl) break; l++; end
    h = 1;
    forever begin @(negedge clk); if (!scl) break; h++; end
  endtask

  task automatic t_reset();
    logic [31:0] d;
    reg_read(2'd0, d); check("R1 ctrl", d, 32'h0);
    reg_read(2'd1, d); check("R1 high", d, 32'hB9);
    reg_read(2'd2, d); check("R1 low", d, 32'hB9);
    check("R1 scl", scl, 1);
    check("R1 irq", irq, 0);
  endtask

  task automatic t_period();
    int h, l;
    reg_write(2'd1, 32'd3);
    reg_write(2'd2, 32'd5);
    measure(h, l);
    measure(h, l);
    check("R2 high len", h, 3);
    check("R2 low len", l, 5);
  endtask

  task automatic t_midphase();
    int h1 = 1, l1 = 0, h2 = 0;
    logic prev = scl;
    forever begin
      @(negedge clk);
      if (!prev && scl) break;
      prev = scl;
    end
    reg_wr = 1'b1; reg_addr = 2'd1; reg_wdata = 32'd7;
    @(negedge clk);
    reg_wr = 1'b0;
    while (scl)  begin h1++; @(negedge clk); end
    while (!scl) begin l1++; @(negedge clk); end
    while (scl)  begin h2++; @(negedge clk); end
    check("R3 running phase kept", h1, 3);
    check("R3 low unchanged", l1, 5);
    check("R3 next phase new", h2, 7);
  endtask

  task automatic t_zero();
    int h, l;
    reg_write(2'd1, 32'd0);
    reg_write(2'd2, 32'd0);
    measure(h, l);
    measure(h, l);
    check("R4 zero high", h, 1);
    check("R4 zero low", l, 1);
  endtask

  task automatic t_fifo();
    logic [31:0] d;
    reg_write(2'd0, 32'h0);
    for (int i = 0; i < 4; i++) begin
      check("R6 ready before full", host_tx_ready, 1);
      host_push(8'h10 + 8'(i));
    end
    check("R6 ready when full", host_tx_ready, 0);
    host_push(8'hEE);
    reg_read(2'd3, d); check("R10 tx full status", d[5], 0);
    eng_tx_ready = 1'b1;
    for (int i = 0; i < 4; i++) begin
      #1;
      check("R6 order valid", eng_tx_valid, 1);
      check("R6 order data", eng_tx_data, 8'h10 + 8'(i));
      @(negedge clk);
    end
    #1;
    check("R6 drop when full", eng_tx_valid, 0);
    eng_tx_ready = 1'b0;
  endtask

  task automatic t_irq();
    reg_write(2'd0, 32'h0);
    check("R5 irq off", irq, 0);
    reg_write(2'd0, 32'h80);
    check("R5 tx not full irq", irq, 1);
    for (int i = 0; i < 4; i++) host_push(8'(i));
    check("R5 tx full irq", irq, 0);
    reg_write(2'd0, 32'h40);
    check("R5 rx empty irq", irq, 0);
    eng_push(8'h5A);
    check("R5 rx data irq", irq, 1);
    check("R6 rx data", host_rx_data, 8'h5A);
    host_rx_ready = 1'b1;
    @(negedge clk);
    host_rx_ready = 1'b0;
    check("R5 rx drained irq", irq, 0);
  endtask

  task automatic t_status_reserved();
    logic [31:0] d;
    eng_evt = 4'b0100;
    @(negedge clk);
    eng_evt = 4'b0000;
    @(negedge clk);
    reg_read(2'd3, d); check("R10 sticky", d[3:0], 4'b0100);
    reg_write(2'd3, 32'hFFFF_FFFF);
    reg_read(2'd3, d); check("R9 status write ignored", d[3:0], 4'b0100);
    reg_write(2'd0, 32'hFFFF_FE00);
    reg_read(2'd0, d); check("R9 reserved ctrl", d, 32'h0);
  endtask

  task automatic t_srst();
    logic [31:0] d;
    int h = 0;
    reg_write(2'd1, 32'd4);
    reg_write(2'd2, 32'd6);
    reg_write(2'd0, 32'hC5);
    eng_push(8'h33);
    eng_evt = 4'b0011;
    reg_write(2'd0, 32'h1C5);
    eng_evt = 4'b0000;
    reg_read(2'd0, d); check("R7 bit reads one", d, 32'h1C5);
    check("R11 ready low", host_tx_ready, 0);
    host_tx_valid = 1'b1; host_tx_data = 8'hAB;
    @(negedge clk);
    host_tx_valid = 1'b0;
    reg_read(2'd0, d); check("R8 ctrl kept, R7 self clear", d, 32'hC5);
    reg_read(2'd1, d); check("R8 high kept", d, 32'd4);
    reg_read(2'd2, d); check("R8 low kept", d, 32'd6);
    reg_read(2'd3, d); check("R7 status cleared", d[3:0], 4'b0);
    check("R7 rx flushed", host_rx_valid, 0);
    check("R11 push discarded", eng_tx_valid, 0);
    check("R5 irq after flush", irq, 1);
    while (scl) begin h++; @(negedge clk); end
    check("R7 scl restarts high", h, 4);
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_period();
    t_midphase();
    t_zero();
    t_fifo();
    t_srst();
    t_irq();
    t_status_reserved();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule